// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between a single-beat internal request port and an external asynchronous static RAM of 64K 16-bit words. The RAM has active-low chip select, output enable, write strobe and one select per byte lane. A request is a one-cycle strobe that carries a direction flag, a word address, write data and a per-lane mask. The sequencer runs the RAM through a setup phase, an access phase and a hold phase. It then raises a one-cycle ready pulse. For a read, the captured word is presented alongside that pulse.

Each phase length is a cycle count. It is derived at elaboration time from a nanosecond timing parameter and the clock period, by ceiling division with a floor of one cycle. The external data bus is modelled as separate in and out vectors plus a drive enable, which the chip top turns into a tri-state pad. The drive enable is raised only after the RAM's outputs are guaranteed to have floated. Requests that arrive while a transaction is in flight are dropped.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and afterwards until the first request, chip select, output enable and write strobe are high, both lane selects are high, the data drive enable is low and ready is low.
- R2: The write strobe goes low only while chip select is low, output enable is high and at least one lane select is low.
- R3: Mask bit 0 drives lane select 0, which gates data bits 7:0. Mask bit 1 drives lane select 1, which gates bits 15:8. A write changes only the selected lanes of the addressed word.
- R4: A write holds the address, with the strobe high, for ceil(20 ns / period) cycles. The strobe then stays low for max(ceil(40/period), ceil(25/period)) cycles. A hold of at least one cycle follows, and is stretched so the whole write spans at least ceil(55/period) cycles.
- R5: A write whose mask is 2'b00 never lowers chip select or the write strobe. Ready still pulses, two cycles after the request is accepted.
- R6: The data drive enable is high in exactly the cycles in which the write strobe is low. It falls in the same cycle the strobe rises, and the driven word equals the requested write data.
- R7: The write strobe never falls until output enable has been high for at least ceil(20/period) consecutive cycles. After a read, chip select stays high for that many cycles before the sequence completes.
- R8: A read lowers chip select with the strobe high. It then lowers output enable and samples the data bus on the last access cycle. By that point chip select has been low for at least ceil(55/period) cycles and output enable for at least ceil(25/period) cycles.
- R9: In the read data, lanes whose mask bit is 0 read as zero.
- R10: Ready is high for exactly one cycle, the cycle after the final hold cycle. For a read, the read data is valid while ready is high.
- R11: A request strobe raised while a transaction is in progress is ignored. The address, the sequence and the number of ready pulses are unchanged.
- R12: The RAM address does not change while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit i selects bits 8i+7:8i |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_ben_n | output | 2 | RAM lane selects, active low |
| mem_dout | output | 16 | Data toward the RAM |
| mem_dout_en | output | 1 | Pad drive enable for mem_dout |
| mem_din | input | 16 | Data from the RAM pads |

## Verification
Two events can share a cycle: the ready pulse that ends one transaction, and the acceptance of the next request. A further case is a request raised while the sequencer is busy. Both are provoked with back-to-back reads and writes, and with a second strobe raised during a transaction's setup phase. The bench drives a RAM model that returns junk until the chip-select and output-enable delays have elapsed, and junk on deselected lanes. Every cycle is judged against a per-phase expectation. That expectation covers the strobes, the lane selects, the drive enable, the address, the driven data and the exact cycle of the single ready pulse.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
module sram_lane_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  output logic          expired
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)             remain <= '0;
    else if (load)          remain <= load_len - CW'(1);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int LANES   = 2,
  parameter int CW      = 8,
  parameter int W_SETUP = 2,
  parameter int W_ACC   = 4,
  parameter int W_HOLD  = 1,
  parameter int R_SETUP = 2,
  parameter int R_ACC   = 4,
  parameter int R_HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  input  logic             phase_done,
  output logic             tmr_load,
  output logic [CW-1:0]    tmr_len,
  output logic [LANES-1:0] mask_q,
  output logic             cap_evt,
  output logic             done_evt,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_ben_n,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en
);
  phase_t          phase;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            accept_evt;
  logic            empty_wr;
  logic            selected;

  assign accept_evt = (phase == PH_IDLE) && req;
  assign empty_wr   = req_wr && (req_mask == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (req) begin
          wr_q    <= req_wr;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          phase   <= empty_wr ? PH_HOLD : PH_SETUP;
        end
        PH_SETUP:  if (phase_done) phase <= PH_ACCESS;
        PH_ACCESS: if (phase_done) phase <= PH_HOLD;
        PH_HOLD:   if (phase_done) phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  // timer reload: length of the phase being entered
  always_comb begin
    tmr_load = accept_evt ||
               (((phase == PH_SETUP) || (phase == PH_ACCESS)) && phase_done);
    unique case (phase)
      PH_IDLE:   tmr_len = empty_wr ? CW'(1) : (req_wr ? CW'(W_SETUP) : CW'(R_SETUP));
      PH_SETUP:  tmr_len = wr_q ? CW'(W_ACC)  : CW'(R_ACC);
      PH_ACCESS: tmr_len = wr_q ? CW'(W_HOLD) : CW'(R_HOLD);
      default:   tmr_len = CW'(1);
    endcase
  end

  assign selected    = (phase == PH_SETUP) || (phase == PH_ACCESS);
  assign cap_evt     = (phase == PH_ACCESS) && !wr_q && phase_done;
  assign done_evt    = (phase == PH_HOLD) && phase_done;

  assign mem_addr    = addr_q;
  assign mem_dout    = wdata_q;
  assign mem_ce_n    = !selected;
  assign mem_ben_n   = selected ? ~mask_q : '1;
  assign mem_oe_n    = !((phase == PH_ACCESS) && !wr_q);
  assign mem_we_n    = !((phase == PH_ACCESS) && wr_q);
  assign mem_dout_en = (phase == PH_ACCESS) && wr_q;
endmodule

// File: rtl/sram_lane_capture.sv
`timescale 1ns/1ps
module sram_lane_capture #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [LANES-1:0] mask,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    rdata
);
  localparam int LW = DW / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)       rdata[l*LW +: LW] <= '0;
      else if (cap_evt) rdata[l*LW +: LW] <= mask[l] ? din[l*LW +: LW] : '0;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_TURN_NS = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_wr,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_mask,
  output logic            rdy,
  output logic [DW-1:0]   rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [DW/8-1:0] mem_ben_n,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_dout_en,
  input  logic [DW-1:0]   mem_din
);
  localparam int LANES   = DW / 8;
  localparam int TURN_C  = ns_to_cyc(T_TURN_NS, CLK_NS);
  localparam int W_SETUP = TURN_C;
  localparam int W_ACC   = imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int W_HOLD  = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - W_SETUP - W_ACC);
  localparam int R_SETUP = TURN_C;
  localparam int R_ACC   = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                     ns_to_cyc(T_RC_NS, CLK_NS)) - R_SETUP,
                                ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int R_HOLD  = TURN_C;

  // named internal events
  logic             phase_done;
  logic             tmr_load;
  logic [CW-1:0]    tmr_len;
  logic [LANES-1:0] mask_q;
  logic             cap_evt;
  logic             done_evt;

  sram_lane_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_len(tmr_len),
    .expired(phase_done)
  );

  sram_lane_seq #(
    .AW(AW), .DW(DW), .LANES(LANES), .CW(CW),
    .W_SETUP(W_SETUP), .W_ACC(W_ACC), .W_HOLD(W_HOLD),
    .R_SETUP(R_SETUP), .R_ACC(R_ACC), .R_HOLD(R_HOLD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .phase_done(phase_done), .tmr_load(tmr_load), .tmr_len(tmr_len),
    .mask_q(mask_q), .cap_evt(cap_evt), .done_evt(done_evt),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ben_n(mem_ben_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en)
  );

  sram_lane_capture #(.DW(DW), .LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .mask(mask_q),
    .din(mem_din), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rdy <= 1'b0;
    else        rdy <= done_evt;
  end
endmodule

// File: rtl/sram_lane_chk.sv
`timescale 1ns/1ps
module sram_lane_chk
  import sram_lane_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LANES     = 2,
  parameter int CLK_NS    = 10,
  parameter int T_PWE_NS  = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_TURN_NS = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_ce_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic [LANES-1:0] mem_ben_n,
  input logic             mem_dout_en,
  input logic             rdy
);
  localparam int PULSE_C = imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int TURN_C  = ns_to_cyc(T_TURN_NS, CLK_NS);

  logic [15:0] we_lo_cnt;
  logic [15:0] oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= '0;
    end else begin
      we_lo_cnt <= mem_we_n ? 16'd0 : ((we_lo_cnt == 16'hFFFF) ? we_lo_cnt : we_lo_cnt + 16'd1);
      oe_hi_cnt <= !mem_oe_n ? 16'd0 : ((oe_hi_cnt == 16'hFFFF) ? oe_hi_cnt : oe_hi_cnt + 16'd1);
    end
  end

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && (mem_ben_n == '1) && !mem_dout_en));

  a_r2_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && (mem_ben_n != '1)));

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= 16'(PULSE_C)));

  a_r6_drive_only_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_oe_n && !mem_ce_n));

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (oe_hi_cnt >= 16'(TURN_C)));

  a_r8_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dout_en));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);

  a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .AW(AW), .LANES(DW/8), .CLK_NS(CLK_NS),
  .T_PWE_NS(T_PWE_NS), .T_SD_NS(T_SD_NS), .T_TURN_NS(T_TURN_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ben_n(mem_ben_n),
  .mem_dout_en(mem_dout_en), .rdy(rdy)
);

// File: tb/sram_lane_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;
  localparam int PER = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rdy;
  logic [15:0] rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [1:0]  mem_ben_n;
  logic [15:0] mem_dout;
  logic [15:0] mem_din;

  int n_chk = 0;
  int n_bad = 0;
  int ce_cnt = 0;
  int oe_cnt = 0;
  logic [15:0] ram     [256];
  logic [15:0] exp_ram [256];

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rdy(rdy), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ben_n(mem_ben_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // RAM model: junk until access delays elapse, junk on deselected lanes
  always_ff @(posedge clk) begin
    ce_cnt <= mem_ce_n ? 0 : ce_cnt + 1;
    oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;
    for (int l = 0; l < 2; l++)
      if (!mem_ce_n && !mem_we_n && mem_dout_en && !mem_ben_n[l])
        ram[mem_addr[7:0]][l*8 +: 8] <= mem_dout[l*8 +: 8];
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ben_n[l] &&
          (ce_cnt + 1) * PER >= 55 && (oe_cnt + 1) * PER >= 25)
        mem_din[l*8 +: 8] = ram[mem_addr[7:0]][l*8 +: 8];
      else
        mem_din[l*8 +: 8] = 8'hE7;
    end
  end

  function automatic int cyc(input int ns);
    int c = 0;
    while (c * PER < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // {ce_n, oe_n, we_n, ben_n[1:0], dout_en, rdy}
  function automatic logic [6:0] vec();
    return {mem_ce_n, mem_oe_n, mem_we_n, mem_ben_n, mem_dout_en, rdy};
  endfunction

  task automatic xact(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit poke);
    int s, ac, h, tot;
    logic [6:0] e;
    logic [15:0] want;
    bit skip;
    string tag;
    skip = wr && (m == 2'b00);
    if (skip) begin s = 0; ac = 0; h = 1; end
    else if (wr) begin
      s = cyc(20);
      ac = (cyc(40) > cyc(25)) ? cyc(40) : cyc(25);
      h = cyc(55) - s - ac; if (h < 1) h = 1;
    end else begin
      s = cyc(20);
      ac = cyc(55) - s; if (ac < cyc(25)) ac = cyc(25);
      h = cyc(20);
    end
    tot = s + ac + h;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
    for (int i = 0; i < tot; i++) begin
      @(negedge clk);
      if (i == 0) req = 1'b0;
      if (poke && i == 1) begin req = 1'b1; req_addr = a ^ 16'h00FF; req_wr = !wr; end
      if (poke && i == 2) req = 1'b0;
      if (i < s) begin
        e = {1'b0, 1'b1, 1'b1, ~m, 1'b0, 1'b0}; tag = "R4 setup";
      end else if (i < s + ac) begin
        if (wr) begin e = {1'b0, 1'b1, 1'b0, ~m, 1'b1, 1'b0}; tag = "R2 R6 write pulse"; end
        else    begin e = {1'b0, 1'b0, 1'b1, ~m, 1'b0, 1'b0}; tag = "R8 read access"; end
      end else begin
        e = 7'b1111100; tag = skip ? "R5 empty write" : "R7 hold";
      end
      if (poke && i == 2) tag = {tag, " R11 busy request"};
      check(vec() == e, tag, 32'(vec()), 32'(e));
      if (!mem_ce_n) check(mem_addr == a, "R12 R11 address", 32'(mem_addr), 32'(a));
      if (mem_dout_en) check(mem_dout == d, "R3 R6 drive data", 32'(mem_dout), 32'(d));
    end
    @(negedge clk);
    check(vec() == 7'b1111101, "R10 ready pulse", 32'(vec()), 32'h7D);
    if (wr) begin
      for (int l = 0; l < 2; l++)
        if (m[l]) exp_ram[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    end else begin
      for (int l = 0; l < 2; l++)
        want[l*8 +: 8] = m[l] ? exp_ram[a[7:0]][l*8 +: 8] : 8'h00;
      check(rdata == want, (m == 2'b11) ? "R8 R3 read data" : "R9 masked read",
            32'(rdata), 32'(want));
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(vec() == 7'b1111100, "R10 R11 idle after ready", 32'(vec()), 32'h7C);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]     = 16'(i * 16'h0101) ^ 16'h3C5A;
      exp_ram[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
    end
    repeat (3) @(negedge clk);
    check(vec() == 7'b1111100, "R1 in reset", 32'(vec()), 32'h7C);
    rst_n = 1'b1;
    @(negedge clk);
    check(vec() == 7'b1111100 && !mem_dout_en, "R1 after reset", 32'(vec()), 32'h7C);

    xact(1'b0, 16'h0010, 16'h0, 2'b11, 1'b0);   // read initial content
    xact(1'b1, 16'h0010, 16'hA1B2, 2'b11, 1'b0); // full write back to back
    xact(1'b0, 16'h0010, 16'h0, 2'b11, 1'b0);
    xact(1'b1, 16'h0020, 16'h5566, 2'b01, 1'b0); // low lane only
    xact(1'b0, 16'h0020, 16'h0, 2'b11, 1'b0);
    xact(1'b1, 16'h0030, 16'h7788, 2'b10, 1'b1); // high lane, busy poke
    idle_check();
    xact(1'b0, 16'h0030, 16'h0, 2'b11, 1'b1);    // read, busy poke
    idle_check();
    xact(1'b1, 16'h0040, 16'hFFFF, 2'b00, 1'b0); // empty write
    xact(1'b0, 16'h0040, 16'h0, 2'b11, 1'b0);
    xact(1'b0, 16'h0010, 16'h0, 2'b01, 1'b0);    // masked reads
    xact(1'b0, 16'h0010, 16'h0, 2'b10, 1'b0);
    xact(1'b0, 16'h0010, 16'h0, 2'b00, 1'b0);
    idle_check();
    finish_run();
  end
endmodule